// File: doc/BRIEF.md
# Serial Identification Number Target on a Two-Wire Bus

This block is a target on an I2C/SMBus two-wire bus. It answers only at one fixed 7-bit address and serves an identification number that is fixed at build time, together with one writable control byte. A bus controller first sets an internal register pointer with a write transfer. It then reads the identification bytes, one byte per acknowledge cycle, while the pointer advances on its own.

The system clock samples both bus lines through a short synchronizer. The block finds START and STOP conditions and the clock edges from those samples. Its only bus output is an open-drain pull-down enable for the data line. The block never touches the clock line. The system clock must run at least ten times faster than the bus clock, so Standard-mode (100 kbit/s) and Fast-mode (400 kbit/s) rates both work with an ordinary system clock.

Top module: `sid_target`

## Requirements
- R1: A first byte after START whose upper seven bits equal DEV_ADDR (default 7'b1010000) is acknowledged. The target pulls SDA low during the ninth clock. Bit 0 of that byte selects the direction: 0 for write and 1 for read.
- R2: A first byte with any other address is not acknowledged. The target then leaves SDA released until the next START.
- R3: Every byte moves most significant bit first. Register k, for k in 0..ID_BYTES-1, returns bits [8k+7:8k] of ID_VALUE.
- R4: In a write transfer the first data byte loads the register pointer. Each later byte is a register write at the pointer. The target acknowledges every data byte.
- R5: The control byte sits at register ID_BYTES (0x08 by default). It is writable, reads back its stored value, and appears on ctrl_o.
- R6: A write to any register other than the control byte is acknowledged but discarded. The identification bytes and the control byte keep their values.
- R7: The pointer advances after each byte read or written and holds at 0xFF. Registers above the control byte read as 0xFF.
- R8: A repeated START restarts the address phase and keeps the pointer, so a pointer write followed by a repeated-START read begins at that pointer.
- R9: When the controller answers a read byte with NACK (SDA high), the target releases SDA for the rest of the transfer.
- R10: A STOP releases SDA and returns the target to idle. The pointer is kept for the next transfer.
- R11: After reset SDA is released, ctrl_o equals CTRL_INIT, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| ctrl_o | output | 8 | Current value of the control register |

## Verification
The address decoder is swept over all 128 seven-bit addresses. This separates the single acknowledged code from every near miss, and it shows that a rejected target never pulls the line while the next byte is clocked. Pointer writes followed by repeated-START reads are swept over every start position from 0 to 12. This covers each identification byte, the control byte and the 0xFF region, so a byte-order or boundary error in the read path is exposed. Runs of writes over the identification range and a range of control values separate discarded writes from stored ones. Pointer saturation at 0xFF, a NACK in mid-read and pointer retention across STOP are each tried on their own.

// File: rtl/sid_pkg.sv
package sid_pkg;

    localparam int SID_BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } sid_state_e;

    // Synchronized bus levels and the conditions found on them
    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } sid_bus_ev_t;

    function automatic logic sid_addr_hit(logic [7:0] b, logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

    function automatic logic [7:0] sid_ptr_next(logic [7:0] p);
        return (p == 8'hFF) ? p : p + 8'd1;
    endfunction

endpackage

// File: rtl/sid_sync.sv
module sid_sync
    import sid_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output sid_bus_ev_t ev
);
    logic [1:0] raw;
    logic [1:0] sync;
    logic [1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign sync[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b11;
        else     prev <= sync;
    end

    always_comb begin
        ev.scl   = sync[1];
        ev.sda   = sync[0];
        ev.start = sync[1] & prev[1] & prev[0] & ~sync[0];
        ev.stop  = sync[1] & prev[1] & ~prev[0] & sync[0];
        ev.rise  = sync[1] & ~prev[1];
        ev.fall  = ~sync[1] & prev[1];
    end
endmodule

// File: rtl/sid_regfile.sv
module sid_regfile #(
    parameter int                    ID_BYTES  = 8,
    parameter logic [8*ID_BYTES-1:0] ID_VALUE  = '0,
    parameter logic [7:0]            CTRL_INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [7:0] ctrl
);
    localparam logic [7:0] CTRL_ADDR = 8'(ID_BYTES);

    logic [7:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_INIT;
        else if (wr_en && addr == CTRL_ADDR)
            ctrl_q <= wr_data;
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < ID_BYTES; i++)
            if (addr == i[7:0]) rd_data = ID_VALUE[8*i +: 8];
        if (addr == CTRL_ADDR) rd_data = ctrl_q;
    end

    assign ctrl = ctrl_q;

    AST_CTRL_ONLY_AT_ITS_ADDR: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q) |-> $past(wr_en && addr == CTRL_ADDR)); // R6
endmodule

// File: rtl/sid_target.sv
module sid_target
    import sid_pkg::*;
#(
    parameter logic [6:0]            DEV_ADDR    = 7'b1010000,
    parameter int                    ID_BYTES    = 8,
    parameter logic [8*ID_BYTES-1:0] ID_VALUE    = 64'h0123_4567_89AB_CDEF,
    parameter logic [7:0]            CTRL_INIT   = 8'h00,
    parameter int                    SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] ctrl_o
);
    localparam int CNT_W = $clog2(SID_BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SID_BYTE_W);

    sid_bus_ev_t      ev;
    sid_state_e       state;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txsh;
    logic [7:0]       ptr;
    logic             rw;
    logic             ptr_load;
    logic             nack;
    logic             oe;
    logic             wr_en;
    logic [7:0]       rd_data;

    sid_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign wr_en = (state == ST_WR) && ev.fall && (bitcnt == LAST_BIT) && !ptr_load
                   && !ev.start && !ev.stop;

    sid_regfile #(
        .ID_BYTES  (ID_BYTES),
        .ID_VALUE  (ID_VALUE),
        .CTRL_INIT (CTRL_INIT)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (ptr),
        .wr_data (shreg),
        .rd_data (rd_data),
        .ctrl    (ctrl_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txsh     <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            ptr_load <= 1'b0;
            nack     <= 1'b0;
            oe       <= 1'b0;
        end else if (ev.start) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            ptr_load <= 1'b1;
            oe       <= 1'b0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
            oe    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall && bitcnt == LAST_BIT) begin
                        bitcnt <= '0;
                        if (sid_addr_hit(shreg, DEV_ADDR)) begin
                            oe    <= 1'b1;
                            rw    <= shreg[0];
                            state <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK, ST_RD_ACK: begin
                    if (ev.rise) nack <= ev.sda;
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (state == ST_RD_ACK && nack) begin
                            oe    <= 1'b0;
                            state <= ST_IDLE;
                        end else if (state == ST_RD_ACK || rw) begin
                            txsh  <= rd_data;
                            oe    <= ~rd_data[7];
                            ptr   <= sid_ptr_next(ptr);
                            state <= ST_RD;
                        end else begin
                            oe    <= 1'b0;
                            state <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall && bitcnt == LAST_BIT) begin
                        bitcnt   <= '0;
                        oe       <= 1'b1;
                        state    <= ST_WR_ACK;
                        ptr_load <= 1'b0;
                        ptr      <= ptr_load ? shreg : sid_ptr_next(ptr);
                    end
                end
                ST_WR_ACK: begin
                    if (ev.fall) begin
                        oe    <= 1'b0;
                        state <= ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev.rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall) begin
                        if (bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            oe     <= 1'b0;
                            state  <= ST_RD_ACK;
                        end else begin
                            txsh <= {txsh[6:0], 1'b0};
                            oe   <= ~txsh[6];
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe_o = oe;

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && bitcnt == '0 && !oe)); // R8
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !oe)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !oe); // R2
    AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= LAST_BIT); // R3
    AST_OE_MOVES_ON_LOW_SCL: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> !ev.scl); // R1
endmodule

// File: tb/sid_target_tb.sv
module sid_target_tb;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 5;
    localparam int         LIMIT      = 190000;
    localparam logic [6:0] DEV        = 7'b1010000;
    localparam logic [63:0] ID        = 64'h8E3B_52C7_1F60_A94D;
    localparam logic [7:0] CINIT      = 8'h3C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [7:0] ctrl;
    logic sda_bus;
    logic [7:0] ctrl_model;
    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    sid_target #(
        .DEV_ADDR (DEV),
        .ID_BYTES (8),
        .ID_VALUE (ID),
        .CTRL_INIT(CINIT)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .ctrl_o   (ctrl)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == LIMIT && !done) begin
            nchk  = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL watchdog act=%0d exp=<%0d cycles", cyc, LIMIT);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    function automatic logic [7:0] exp_reg(int p, logic [7:0] c);
        if (p < 8)  return ID[8*p +: 8];
        if (p == 8) return c;
        return 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic r);
        wclk(Q);
        sda_m = b;
        wclk(Q);
        scl_m = 1'b1;
        wclk(Q);
        r = sda_bus;
        wclk(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            wclk(Q);
            sda_m = 1'b1;
            wclk(Q);
            scl_m = 1'b1;
        end
        wclk(2*Q);
        sda_m = 1'b0;
        wclk(2*Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wclk(Q);
        sda_m = 1'b0;
        wclk(Q);
        scl_m = 1'b1;
        wclk(2*Q);
        sda_m = 1'b1;
        wclk(4*Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xfer_bit(d[i], r);
        xfer_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic nk, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            xfer_bit(1'b1, r);
            d = {d[6:0], r};
        end
        xfer_bit(nk, r);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        wr_byte({DEV, 1'b0}, a);
        chk("R1 addr ack", 32'(a), 1);
        wr_byte(p, a);
        chk("R4 pointer ack", 32'(a), 1);
    endtask

    initial begin
        logic a;
        logic [7:0] d;
        int p;
        ctrl_model = CINIT;
        wclk(5);
        rst = 1'b0;
        wclk(2);
        // R11: reset state
        chk("R11 sda released", 32'(sda_oe), 0);
        chk("R11 ctrl init", 32'(ctrl), 32'(CINIT));
        // R11: pointer starts at 0, current read gives byte 0
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(1'b1, d);
        chk("R11 pointer zero", 32'(d), 32'(exp_reg(0, ctrl_model)));
        bus_stop();

        // R1 and R2: sweep every 7-bit address
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            wr_byte({ad[6:0], ad[0]}, a);
            if (ad[6:0] == DEV) begin
                chk("R1 match ack", 32'(a), 1);
                if (ad[0]) begin
                    rd_byte(1'b1, d);
                end
            end else begin
                chk("R2 mismatch nack", 32'(a), 0);
                rd_byte(1'b1, d);
                chk("R2 no drive after mismatch", 32'(d), 32'hFF);
            end
            bus_stop();
        end

        // R3, R5, R7: sequential read from 0 across the whole map
        set_ptr(8'h00);
        bus_stop();
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        chk("R1 read addr ack", 32'(a), 1);
        for (int i = 0; i < 12; i++) begin
            rd_byte(i == 11, d);
            chk(i < 8 ? "R3 id byte" : (i == 8 ? "R5 ctrl read" : "R7 beyond map"),
                32'(d), 32'(exp_reg(i, ctrl_model)));
        end
        bus_stop();
        chk("R10 released after stop", 32'(sda_oe), 0);

        // R4, R5: control writes with readback via repeated START (R8)
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = 8'(k * 8'h2B) ^ 8'hA5;
            set_ptr(8'h08);
            wr_byte(v, a);
            chk("R4 data ack", 32'(a), 1);
            ctrl_model = v;
            bus_stop();
            chk("R5 ctrl_o", 32'(ctrl), 32'(v));
            set_ptr(8'h08);
            bus_start();
            wr_byte({DEV, 1'b1}, a);
            rd_byte(1'b1, d);
            chk("R5 ctrl readback", 32'(d), 32'(v));
            bus_stop();
        end

        // R6: writes over the id bytes and past the control byte are dropped
        set_ptr(8'h00);
        for (int i = 0; i < 8; i++) begin
            wr_byte(8'h5A ^ 8'(i), a);
            chk("R6 id write acked", 32'(a), 1);
        end
        bus_stop();
        set_ptr(8'h09);
        wr_byte(8'h77, a);
        chk("R6 high write acked", 32'(a), 1);
        wr_byte(8'h66, a);
        bus_stop();
        chk("R6 ctrl unchanged", 32'(ctrl), 32'(ctrl_model));

        // R8: pointer then repeated-START read, every start position
        for (int s = 0; s <= 12; s++) begin
            set_ptr(8'(s));
            bus_start();
            wr_byte({DEV, 1'b1}, a);
            chk("R8 read addr ack", 32'(a), 1);
            rd_byte(1'b0, d);
            chk("R8 first byte", 32'(d), 32'(exp_reg(s, ctrl_model)));
            rd_byte(1'b1, d);
            chk("R7 next byte", 32'(d), 32'(exp_reg(s + 1, ctrl_model)));
            bus_stop();
        end

        // R7: saturation at 0xFF
        set_ptr(8'hFE);
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        for (int i = 0; i < 3; i++) begin
            rd_byte(i == 2, d);
            chk("R7 saturate read", 32'(d), 32'hFF);
        end
        bus_stop();
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(1'b1, d);
        chk("R7 held at FF", 32'(d), 32'hFF);
        bus_stop();

        // R9: NACK releases SDA for the rest of the transfer
        set_ptr(8'h01);
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(1'b1, d);
        chk("R9 byte before nack", 32'(d), 32'(exp_reg(1, ctrl_model)));
        rd_byte(1'b0, d);
        chk("R9 released after nack", 32'(d), 32'hFF);
        rd_byte(1'b1, d);
        chk("R9 still released", 32'(d), 32'hFF);
        bus_stop();

        // R10: pointer kept across STOP
        p = 3;
        set_ptr(8'(p));
        bus_stop();
        chk("R10 oe after stop", 32'(sda_oe), 0);
        bus_start();
        wr_byte({DEV, 1'b1}, a);
        rd_byte(1'b1, d);
        chk("R10 pointer kept", 32'(d), 32'(exp_reg(p, ctrl_model)));
        bus_stop();

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule